// File: doc/BRIEF.md
# Bit-Granular Unaligned Load/Store Unit

This unit sits between an execution core and a memory whose words are 85 bits wide, in a machine where every bit has its own signed address. A request names the lowest bit address of an item and a length of 0 to 255 bits. The unit breaks the request into aligned word accesses, issuing one per cycle on a simple synchronous memory port with a per-bit write mask. Loads come back right-justified at bit 0, least significant bit taken from the lowest address. Stores change only the bits the item covers.

Only one request is in flight at a time. Requests therefore complete strictly in the order they were accepted, which is the ordering that synchronized accesses need. With each response the unit reports whether the item crosses an 85-bit word boundary and whether its address is 85-bit aligned. A zero-length request completes without any memory traffic.

Top module: `lsu_bitaddr_unit`

## Requirements
- R1: The first word index is floor(addr / 85), rounding toward minus infinity, and the bit offset inside that word is addr - 85 * index, in the range 0 to 84. A request at address -1 starts in word -1 at offset 84.
- R2: A request of length L > 0 issues floor((offset + L - 1) / 85) + 1 word accesses on consecutive cycles, starting in the cycle after acceptance, with word indices ascending by one. At most 4 accesses are issued. mem_en stays low in all other cycles.
- R3: For a load, rsp_rdata bit j equals memory bit addr + j for every j < L. Word bit i of word w holds address 85 * w + i. rsp_rdata bits at positions L and above are zero.
- R4: For a store, mem_we is high on every issued access. mem_wmask bit i is set exactly when address 85 * w + i lies within addr to addr + L - 1. Under the mask, mem_wdata carries req_wdata bit (address - addr). req_wdata bits at positions L and above have no effect on memory.
- R5: A zero-length request issues no memory access.
- R6: rsp_valid is a single-cycle pulse that arrives N + 2 cycles after the acceptance cycle, where N is the number of word accesses (0 when L = 0).
- R7: rsp_cross is 1 exactly when the item occupies more than one 85-bit word, that is, when it contains a bit at a multiple of 85 that is not its first bit.
- R8: rsp_aligned is 1 exactly when addr is a multiple of 85, whatever the length.
- R9: req_ready is 1 in idle and out of reset. It drops in the cycle after acceptance and rises again in the cycle after the response, so requests complete in acceptance order.
- R10: For a store, rsp_rdata is all zeros.
- R11: Memory read data is expected one cycle after its access is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and accepting |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Signed bit address of the item's lowest bit |
| req_len | input | 8 | Item length in bits, 0 to 255 |
| req_wdata | input | 255 | Store data, right-justified |
| rsp_valid | output | 1 | Completion pulse |
| rsp_rdata | output | 255 | Load data, right-justified, upper bits zero |
| rsp_cross | output | 1 | Item spans more than one word |
| rsp_aligned | output | 1 | Address is a multiple of 85 |
| mem_en | output | 1 | Word access strobe |
| mem_we | output | 1 | Word access is a write |
| mem_idx | output | 32 | Signed word index |
| mem_wdata | output | 85 | Word write data |
| mem_wmask | output | 85 | Per-bit write enable |
| mem_rdata | input | 85 | Word read data, one cycle after the access |

## Verification
In a multi-word load, the capture of one returned word falls in the same cycle as the issue of the next word access. The last capture then overlaps the finishing state. These overlaps are provoked with loads that span three and four words, among them a full 255-bit item at offset 84 and an item that straddles address zero from the negative side. The merged result is judged bit by bit against a bench-held map of bit values. Every cycle of each transaction is also compared against a predicted schedule of strobes, indices, masks, ready and response.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ISSUE  = 2'd1,
    ST_FINISH = 2'd2,
    ST_RESP   = 2'd3
  } lsu_state_e;
endpackage

// File: rtl/lsu_addr_split.sv
// Splits a signed bit address into word index and offset (floor division),
// and derives the span of the item in words.
module lsu_addr_split #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int WORD_W = 85,
  parameter int OFF_W  = 7,
  parameter int CNT_W  = 3
) (
  input  logic signed [ADDR_W-1:0] addr,
  input  logic        [LEN_W-1:0]  len,
  output logic signed [ADDR_W-1:0] word_idx,
  output logic        [OFF_W-1:0]  off,
  output logic        [CNT_W-1:0]  nwords,
  output logic                     crosses,
  output logic                     aligned
);
  localparam logic signed [ADDR_W-1:0] WSZ = ADDR_W'(WORD_W);

  logic signed [ADDR_W-1:0] q_trunc;
  logic signed [ADDR_W-1:0] r_trunc;
  int                       last_bit;

  always_comb begin
    q_trunc = addr / WSZ;
    r_trunc = addr - q_trunc * WSZ;
    // truncating division rounds toward zero; fold negatives down (R1)
    if (r_trunc < 0) begin
      word_idx = q_trunc - ADDR_W'(1);
      off      = OFF_W'(r_trunc + WSZ);
    end else begin
      word_idx = q_trunc;
      off      = OFF_W'(r_trunc);
    end
    last_bit = int'(off) + int'(len) - 1;
    if (len == '0) nwords = '0;
    else           nwords = CNT_W'(last_bit / WORD_W + 1);
  end

  assign crosses = (nwords > CNT_W'(1));
  assign aligned = (off == '0);
endmodule

// File: rtl/lsu_wr_align.sv
// Places store data and its bit mask at the item's offset in a multi-word span.
module lsu_wr_align #(
  parameter int MAX_LEN = 255,
  parameter int LEN_W   = 8,
  parameter int OFF_W   = 7,
  parameter int SPAN_W  = 340
) (
  input  logic [MAX_LEN-1:0] wdata,
  input  logic [LEN_W-1:0]   len,
  input  logic [OFF_W-1:0]   off,
  output logic [SPAN_W-1:0]  span_data,
  output logic [SPAN_W-1:0]  span_mask
);
  localparam int PAD_W = SPAN_W - MAX_LEN;

  logic [MAX_LEN-1:0] keep;

  assign keep      = ~({MAX_LEN{1'b1}} << len);
  assign span_mask = {{PAD_W{1'b0}}, keep} << off;
  assign span_data = {{PAD_W{1'b0}}, (wdata & keep)} << off;
endmodule

// File: rtl/lsu_rd_merge.sv
// Collects returned words into a span and extracts the right-justified item.
module lsu_rd_merge #(
  parameter int WORD_W    = 85,
  parameter int MAX_WORDS = 4,
  parameter int MAX_LEN   = 255,
  parameter int LEN_W     = 8,
  parameter int OFF_W     = 7,
  parameter int CNT_W     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               cap_en,
  input  logic [CNT_W-1:0]   cap_k,
  input  logic [WORD_W-1:0]  word_in,
  input  logic [OFF_W-1:0]   off,
  input  logic [LEN_W-1:0]   len,
  output logic [MAX_LEN-1:0] item
);
  localparam int SPAN_W = MAX_WORDS * WORD_W;

  logic [SPAN_W-1:0]  span;
  logic [SPAN_W-1:0]  shifted;
  logic [MAX_LEN-1:0] keep;

  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_slot
    logic [WORD_W-1:0] w_q;
    logic              w_en;
    assign w_en = clear | (cap_en & (cap_k == CNT_W'(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    w_q <= '0;
      else if (w_en) w_q <= clear ? '0 : word_in;
    end
    assign span[g*WORD_W +: WORD_W] = w_q;
  end

  assign shifted = span >> off;
  assign keep    = ~({MAX_LEN{1'b1}} << len);
  assign item    = shifted[MAX_LEN-1:0] & keep;

  // R11: a capture never coincides with the clear of a new request
  a_r11_no_capture_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !cap_en);
endmodule

// File: rtl/lsu_bitaddr_unit.sv
module lsu_bitaddr_unit #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 8,
  parameter int WORD_W  = 85,
  parameter int MAX_LEN = 255
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic signed [ADDR_W-1:0]  req_addr,
  input  logic        [LEN_W-1:0]   req_len,
  input  logic        [MAX_LEN-1:0] req_wdata,
  output logic                      rsp_valid,
  output logic        [MAX_LEN-1:0] rsp_rdata,
  output logic                      rsp_cross,
  output logic                      rsp_aligned,
  output logic                      mem_en,
  output logic                      mem_we,
  output logic signed [ADDR_W-1:0]  mem_idx,
  output logic        [WORD_W-1:0]  mem_wdata,
  output logic        [WORD_W-1:0]  mem_wmask,
  input  logic        [WORD_W-1:0]  mem_rdata
);
  import lsu_pkg::*;

  localparam int OFF_W     = $clog2(WORD_W);
  localparam int MAX_WORDS = (MAX_LEN + WORD_W - 2) / WORD_W + 1;
  localparam int CNT_W     = $clog2(MAX_WORDS + 1);
  localparam int KW        = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;
  localparam int SPAN_W    = MAX_WORDS * WORD_W;

  lsu_state_e state_q, state_n;

  logic signed [ADDR_W-1:0] sp_idx, base_q;
  logic [OFF_W-1:0]         sp_off, off_q;
  logic [CNT_W-1:0]         sp_nw, nw_q, cnt_q, cnt_n;
  logic                     sp_cross, sp_align;
  logic [SPAN_W-1:0]        sp_data, sp_mask, sdata_q, smask_q;
  logic [LEN_W-1:0]         len_q;
  logic                     wr_q, cross_q, align_q;
  logic                     load, issuing, cnt_en;
  logic                     cap_v_q;
  logic [CNT_W-1:0]         cap_k_q;
  logic [WORD_W-1:0]        dword [MAX_WORDS];
  logic [WORD_W-1:0]        mword [MAX_WORDS];

  lsu_addr_split #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .WORD_W(WORD_W), .OFF_W(OFF_W), .CNT_W(CNT_W)
  ) u_split (
    .addr(req_addr), .len(req_len), .word_idx(sp_idx), .off(sp_off),
    .nwords(sp_nw), .crosses(sp_cross), .aligned(sp_align)
  );

  lsu_wr_align #(
    .MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .OFF_W(OFF_W), .SPAN_W(SPAN_W)
  ) u_walign (
    .wdata(req_wdata), .len(req_len), .off(sp_off),
    .span_data(sp_data), .span_mask(sp_mask)
  );

  lsu_rd_merge #(
    .WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS), .MAX_LEN(MAX_LEN),
    .LEN_W(LEN_W), .OFF_W(OFF_W), .CNT_W(CNT_W)
  ) u_merge (
    .clk(clk), .rst_n(rst_n), .clear(load), .cap_en(cap_v_q), .cap_k(cap_k_q),
    .word_in(mem_rdata), .off(off_q), .len(len_q), .item(rsp_rdata)
  );

  // next-state logic
  always_comb begin
    state_n = state_q;
    load    = 1'b0;
    cnt_en  = 1'b0;
    cnt_n   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          load    = 1'b1;
          cnt_en  = 1'b1;
          cnt_n   = '0;
          state_n = (sp_nw == '0) ? ST_FINISH : ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        cnt_en = 1'b1;
        cnt_n  = cnt_q + CNT_W'(1);
        if (cnt_q == nw_q - CNT_W'(1)) state_n = ST_FINISH;
      end
      ST_FINISH: state_n = ST_RESP;
      ST_RESP:   state_n = ST_IDLE;
      default:   state_n = ST_IDLE;
    endcase
  end

  assign issuing = (state_q == ST_ISSUE);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cap_v_q <= 1'b0;
      cap_k_q <= '0;
    end else begin
      state_q <= state_n;
      if (cnt_en) cnt_q <= cnt_n;
      cap_v_q <= issuing & ~wr_q;
      cap_k_q <= cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      off_q   <= '0;
      len_q   <= '0;
      nw_q    <= '0;
      wr_q    <= 1'b0;
      cross_q <= 1'b0;
      align_q <= 1'b0;
      sdata_q <= '0;
      smask_q <= '0;
    end else if (load) begin
      base_q  <= sp_idx;
      off_q   <= sp_off;
      len_q   <= req_len;
      nw_q    <= sp_nw;
      wr_q    <= req_write;
      cross_q <= sp_cross;
      align_q <= sp_align;
      sdata_q <= sp_data;
      smask_q <= sp_mask;
    end
  end

  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_lane
    assign dword[g] = sdata_q[g*WORD_W +: WORD_W];
    assign mword[g] = smask_q[g*WORD_W +: WORD_W];
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign rsp_valid   = (state_q == ST_RESP);
  assign rsp_cross   = cross_q;
  assign rsp_aligned = align_q;
  assign mem_en      = issuing;
  assign mem_we      = issuing & wr_q;
  assign mem_idx     = base_q + ADDR_W'(cnt_q);
  assign mem_wdata   = mem_we ? dword[cnt_q[KW-1:0]] : '0;
  assign mem_wmask   = mem_we ? mword[cnt_q[KW-1:0]] : '0;

  // R5: zero-length request never reaches memory
  a_r5_zero_len_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len == '0) |=> !mem_en);
  // R2: back-to-back accesses walk ascending words
  a_r2_ascending_words: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en)) |-> (mem_idx == $past(mem_idx) + 1));
  // R4: every store access touches at least one bit
  a_r4_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> (mem_wmask != '0));
  // R6: response is a single pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R9: one request in flight
  a_r9_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/lsu_bitaddr_unit_tb.sv
module lsu_bitaddr_unit_tb_top;
  localparam int AW = 32;
  localparam int WW = 85;
  localparam int ML = 255;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 req_valid, req_ready, req_write;
  logic signed [AW-1:0] req_addr;
  logic [7:0]           req_len;
  logic [ML-1:0]        req_wdata;
  logic                 rsp_valid, rsp_cross, rsp_aligned;
  logic [ML-1:0]        rsp_rdata;
  logic                 mem_en, mem_we;
  logic signed [AW-1:0] mem_idx;
  logic [WW-1:0]        mem_wdata, mem_wmask, mem_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lsu_bitaddr_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_cross(rsp_cross),
    .rsp_aligned(rsp_aligned), .mem_en(mem_en), .mem_we(mem_we),
    .mem_idx(mem_idx), .mem_wdata(mem_wdata), .mem_wmask(mem_wmask),
    .mem_rdata(mem_rdata)
  );

  // word memory device, one-cycle read latency (R11)
  logic [WW-1:0] dev [longint];
  logic [WW-1:0] rd_q;
  logic [WW-1:0] dold;
  longint        dk;
  assign mem_rdata = rd_q;

  always @(posedge clk) begin
    if (mem_en) begin
      dk = longint'(mem_idx);
      dold = dev.exists(dk) ? dev[dk] : '0;
      if (mem_we) dev[dk] = (dold & ~mem_wmask) | (mem_wdata & mem_wmask);
      else        rd_q <= dold;
    end
  end

  // reference bit map, one entry per bit address
  bit ref_bits [longint];

  task automatic check(input bit ok, input string tag,
                       input logic [339:0] act, input logic [339:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic longint fdiv(input longint a);
    longint q;
    q = a / 85;
    if (q * 85 > a) q = q - 1;
    return q;
  endfunction

  function automatic logic [ML-1:0] pat();
    logic [255:0] t;
    for (int k = 0; k < 8; k++) t[k*32 +: 32] = $urandom;
    return t[ML-1:0];
  endfunction

  task automatic run_req(input bit wr, input longint addr, input int len,
                         input logic [ML-1:0] wd);
    longint        w0, n, off, b;
    logic [ML-1:0] exp_item;
    logic [WW-1:0] em, ed;
    exp_item = '0;
    w0 = fdiv(addr);
    n  = (len > 0) ? fdiv(addr + len - 1) - w0 + 1 : 0;
    off = addr - 85 * w0;
    for (int j = 0; j < len; j++) begin
      b = addr + j;
      exp_item[j] = ref_bits.exists(b) ? ref_bits[b] : 1'b0;
    end
    if (wr) for (int j = 0; j < len; j++) ref_bits[addr + j] = wd[j];

    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(addr);
    req_len = 8'(len); req_wdata = wd;
    check(req_ready == 1'b1, "R9 ready before accept", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 1; c <= n + 3; c++) begin
      if (c <= n) begin
        check(mem_en == 1'b1, "R2 access strobe", mem_en, 1);
        check(mem_idx == w0 + c - 1, "R1 word index", mem_idx, w0 + c - 1);
        check(mem_we == wr, "R4 write strobe", mem_we, wr);
        if (wr) begin
          for (int i = 0; i < WW; i++) begin
            b = (w0 + c - 1) * 85 + i;
            em[i] = (b >= addr) && (b < addr + len);
            ed[i] = em[i] ? wd[b - addr] : 1'b0;
          end
          check(mem_wmask == em, "R4 write mask", mem_wmask, em);
          check((mem_wdata & em) == ed, "R4 write data", mem_wdata & em, ed);
        end
      end else begin
        check(mem_en == 1'b0, (n == 0) ? "R5 no access" : "R2 idle strobe", mem_en, 0);
      end
      if (c == n + 2) begin
        check(rsp_valid == 1'b1, "R6 response timing", rsp_valid, 1);
        if (wr) check(rsp_rdata == '0, "R10 store data zero", rsp_rdata, 0);
        else    check(rsp_rdata == exp_item, "R3 load data", rsp_rdata, exp_item);
        check(rsp_cross == (n > 1), "R7 cross flag", rsp_cross, n > 1);
        check(rsp_aligned == (off == 0), "R8 aligned flag", rsp_aligned, off == 0);
      end else begin
        check(rsp_valid == 1'b0, "R6 no stray pulse", rsp_valid, 0);
      end
      check(req_ready == (c == n + 3), "R9 ready schedule", req_ready, c == n + 3);
      if (c < n + 3) @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_len = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R9 reset ready", req_ready, 1);
    check(rsp_valid == 1'b0, "R6 reset response", rsp_valid, 0);
    check(mem_en == 1'b0, "R2 reset strobe", mem_en, 0);
    rst_n = 1'b1;

    run_req(1, 182, 12, pat());   run_req(0, 182, 12, '0);
    run_req(1, 850, 122, pat());  run_req(0, 850, 122, '0);
    run_req(1, 84, 255, pat());   run_req(0, 84, 255, '0);
    run_req(1, -1, 2, pat());     run_req(0, -3, 6, '0);
    run_req(1, -85, 85, pat());   run_req(0, -85, 85, '0);
    run_req(1, 5, 0, pat());      run_req(0, 5, 0, '0);
    run_req(1, 300, 5, '1);       run_req(0, 295, 20, '0);
    run_req(0, -200, 255, '0);
    for (int t = 0; t < 40; t++) begin
      run_req(1'($urandom_range(0, 1)), longint'($urandom_range(0, 2000)) - 1000,
              int'($urandom_range(0, 255)), pat());
    end
    run_req(0, -300, 255, '0);
    run_req(0, 170, 255, '0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule